// File: doc/BRIEF.md
# Function-Coded Bus Responder

This block answers a parallel instrumentation bus on which a master presents a 4-bit function code, an 11-bit subaddress and a 16-bit data word, qualified by a one-cycle strobe. The function code selects the operation: push into or pop from a word queue, report the queue pointers or the previously executed command, write or read small register banks indexed by the subaddress, or forward a control-space access to an external register port. The block acknowledges with an active-low response strobe. Its length depends on the code: one clock for a queue pop and three clocks otherwise. Three codes are not answered at all.

A write of 0x80 to control address 0 through the control-write code is a soft clear. It empties the queue, zeroes the bank registers and erases the command history, and it is still forwarded to the external port. Read data is returned on `rdata_o` and is valid while `resp_no` is low.

Top module: `fbus_responder`

## Requirements
- R1: Codes 0x3, 0x7 and 0x9 get no response (`resp_no` stays high), change no state and are not recorded as the previous command.
- R2: Code 0x0 drives `resp_no` low for exactly one clock, starting in the cycle after the strobe edge.
- R3: Every other answered code (0x1, 0x2, 0x4, 0x5, 0x6, 0x8, 0xA to 0xF) drives `resp_no` low for exactly three clocks, starting in the cycle after the strobe edge; writes and code 0xF return 0.
- R4: Code 0x8 pushes `wdata_i` into a FIFO of FIFO_DEPTH (default 1023) words, and code 0x0 pops and returns the oldest word.
- R5: A pop of an empty FIFO returns 0 and leaves both pointers unchanged. A push into a full FIFO is dropped.
- R6: Code 0x1 with subaddress 0 returns the low 8 bits of the write pointer in bits 15..8 and the low 8 bits of the read pointer in bits 7..0. Both pointers start at 0 and wrap from FIFO_DEPTH-1 to 0.
- R7: Code 0x1 with subaddress 1 returns the previous answered command: its code in bits 15..12, 0 in bit 11 and its subaddress in bits 10..0. Code 0x1 with any other subaddress returns 0.
- R8: Codes 0xA, 0xB, 0xC and 0xD write banks 0 to 3 at the register given by the low BANK_AW subaddress bits. Codes 0x2, 0x4 and 0x5 read banks 0, 2 and 3; bank 1 is write-only because its read code 0x3 is unanswered.
- R9: Code 0xE pulses `ctl_we_o` in the strobe cycle with `ctl_addr_o` = subaddress and `ctl_wdata_o` = data. Code 0x6 pulses `ctl_re_o` and returns `ctl_rdata_i` as sampled in that cycle. The two pulses never overlap.
- R10: Code 0xE with subaddress 0 and data 0x0080 clears the banks, the FIFO pointers and the command history; the next code 0x1 / subaddress 1 query returns 0.
- R11: A strobe that arrives while `resp_no` is low is ignored.
- R12: During and after reset `resp_no` is high and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Command qualifier, one cycle |
| func_i | input | 4 | Function code |
| sub_i | input | 11 | Subaddress |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while resp_no is low |
| resp_no | output | 1 | Response strobe, active low |
| ctl_we_o | output | 1 | External control write pulse |
| ctl_re_o | output | 1 | External control read pulse |
| ctl_addr_o | output | 11 | External control address |
| ctl_wdata_o | output | 16 | External control write data |
| ctl_rdata_i | input | 16 | External control read data, combinational |

## Verification
The assertions assume that the master raises `strobe_i` for one cycle and holds the function code and subaddress stable in that cycle. They also assume that `ctl_rdata_i` settles in the same cycle as `ctl_re_o`. The bench drives every field at the falling edge, holds each command for one clock and waits for `resp_no` to return high before the next command. The only exception is the busy-strobe case, which deliberately presents a command inside an acknowledge window to show that it is dropped.

// File: rtl/fbus_pkg.sv
package fbus_pkg;
  typedef enum logic [3:0] {
    FN_POP  = 4'h0, FN_STAT = 4'h1, FN_RDA  = 4'h2, FN_RDB  = 4'h3,
    FN_RDC  = 4'h4, FN_RDD  = 4'h5, FN_CRD  = 4'h6, FN_SKP7 = 4'h7,
    FN_PUSH = 4'h8, FN_SKP9 = 4'h9, FN_WRA  = 4'hA, FN_WRB  = 4'hB,
    FN_WRC  = 4'hC, FN_WRD  = 4'hD, FN_CWR  = 4'hE, FN_SPR  = 4'hF
  } fn_e;

  localparam logic [15:0] SOFT_CLR_WORD = 16'h0080;

  function automatic logic fn_silent(input logic [3:0] f);
    return (f == FN_RDB) || (f == FN_SKP7) || (f == FN_SKP9);
  endfunction
endpackage

// File: rtl/fbus_fifo.sv
module fbus_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 1023,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == CW'(DEPTH));
  assign do_push  = push_i && !full_o;
  assign do_pop   = pop_i && !empty_o;
  assign rdata_o  = empty_o ? '0 : mem_q[rd_q];
  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !clr_i) |=> (cnt_q == CW'(DEPTH)) && $stable(wr_q));
  p_empty_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o && !clr_i) |=> $stable(rd_q) && empty_o);
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/fbus_banks.sv
module fbus_banks #(
  parameter int DW = 16,
  parameter int NB = 4,
  parameter int AW = 4,
  localparam int BW = $clog2(NB),
  localparam int NR = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [BW-1:0] wsel_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [BW-1:0] rsel_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] bank_rd [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] reg_q [NR];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < NR; r++) reg_q[r] <= '0;
      end else if (clr_i) begin
        for (int r = 0; r < NR; r++) reg_q[r] <= '0;
      end else if (we_i && wsel_i == BW'(b)) begin
        reg_q[waddr_i] <= wdata_i;
      end
    end
    assign bank_rd[b] = reg_q[raddr_i];
  end

  assign rdata_o = bank_rd[rsel_i];
endmodule

// File: rtl/fbus_responder.sv
module fbus_responder
  import fbus_pkg::*;
#(
  parameter int DW         = 16,
  parameter int FW         = 4,
  parameter int SW         = 11,
  parameter int FIFO_DEPTH = 1023,
  parameter int BANK_AW    = 4,
  parameter int LONG_ACK   = 3,
  localparam int NB        = 4,
  localparam int BW        = $clog2(NB),
  localparam int PW        = $clog2(FIFO_DEPTH),
  localparam int KW        = $clog2(LONG_ACK + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic [FW-1:0] func_i,
  input  logic [SW-1:0] sub_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          resp_no,
  output logic          ctl_we_o,
  output logic          ctl_re_o,
  output logic [SW-1:0] ctl_addr_o,
  output logic [DW-1:0] ctl_wdata_o,
  input  logic [DW-1:0] ctl_rdata_i
);
  fn_e           fn;
  logic          busy, acc, soft_clr;
  logic [KW-1:0] ack_q;
  logic [DW-1:0] rdata_q, rd_nxt;
  logic [FW-1:0] last_f_q;
  logic [SW-1:0] last_sa_q;

  logic [DW-1:0] fifo_rd, bank_rd;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          fifo_empty, fifo_full;
  logic [BW-1:0] bsel;

  assign fn       = fn_e'(func_i);
  assign busy     = (ack_q != '0);
  assign acc      = strobe_i && !busy && !fn_silent(func_i);
  assign soft_clr = acc && (fn == FN_CWR) && (sub_i == '0) && (wdata_i == SOFT_CLR_WORD);
  assign bsel     = BW'(func_i[BW-1:0] - 2'd2);  // 2/4/5 and A/B/C/D -> 0..3

  assign ctl_we_o    = acc && (fn == FN_CWR);
  assign ctl_re_o    = acc && (fn == FN_CRD);
  assign ctl_addr_o  = sub_i;
  assign ctl_wdata_o = wdata_i;

  fbus_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .clr_i   (soft_clr),
    .push_i  (acc && (fn == FN_PUSH)),
    .pop_i   (acc && (fn == FN_POP)),
    .wdata_i,
    .rdata_o (fifo_rd),
    .wr_ptr_o(wr_ptr),
    .rd_ptr_o(rd_ptr),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  fbus_banks #(.DW(DW), .NB(NB), .AW(BANK_AW)) i_banks (
    .clk_i, .rst_ni,
    .clr_i  (soft_clr),
    .we_i   (acc && (fn inside {FN_WRA, FN_WRB, FN_WRC, FN_WRD})),
    .wsel_i (bsel),
    .waddr_i(sub_i[BANK_AW-1:0]),
    .wdata_i,
    .rsel_i (bsel),
    .raddr_i(sub_i[BANK_AW-1:0]),
    .rdata_o(bank_rd)
  );

  always_comb begin
    rd_nxt = '0;
    unique case (fn)
      FN_POP:  rd_nxt = fifo_rd;
      FN_STAT: begin
        if (sub_i == SW'(0))      rd_nxt = {8'(wr_ptr), 8'(rd_ptr)};
        else if (sub_i == SW'(1)) rd_nxt = {last_f_q, 1'b0, last_sa_q};
      end
      FN_RDA, FN_RDC, FN_RDD: rd_nxt = bank_rd;
      FN_CRD:  rd_nxt = ctl_rdata_i;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q     <= '0;
      rdata_q   <= '0;
      last_f_q  <= '0;
      last_sa_q <= '0;
    end else if (acc) begin
      ack_q   <= (fn == FN_POP) ? KW'(1) : KW'(LONG_ACK);
      rdata_q <= rd_nxt;
      // history is written after the read mux samples it
      last_f_q  <= soft_clr ? '0 : func_i;
      last_sa_q <= soft_clr ? '0 : sub_i;
    end else if (busy) begin
      ack_q <= ack_q - 1'b1;
    end
  end

  assign resp_no = !busy;
  assign rdata_o = rdata_q;

  // checker: measured low run must equal the length implied by the code
  logic [KW:0]   chk_run_q;
  logic [KW-1:0] chk_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_run_q <= '0;
      chk_len_q <= '0;
    end else begin
      if (acc) chk_len_q <= (func_i == '0) ? KW'(1) : KW'(LONG_ACK);
      if (!resp_no) chk_run_q <= chk_run_q + 1'b1;
      else          chk_run_q <= '0;
    end
  end

  p_silent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && resp_no && fn_silent(func_i)) |=> resp_no && $stable(rdata_o));
  p_ack_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && resp_no && !fn_silent(func_i)) |=> !resp_no);
  p_ack_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resp_no) |-> (chk_run_q == (KW+1)'(chk_len_q)));
  p_ext_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_we_o && ctl_re_o));
  p_busy_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_no |=> $stable(rdata_o) && $stable(last_f_q) && $stable(last_sa_q));
  p_idle_hi_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_no && !strobe_i) |=> resp_no);
endmodule

// File: tb/test_fbus_responder.sv
module test_fbus_responder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [3:0]  func_i = '0;
  logic [10:0] sub_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        resp_no;
  logic        ctl_we_o, ctl_re_o;
  logic [10:0] ctl_addr_o;
  logic [15:0] ctl_wdata_o, ctl_rdata_i;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int ext_wr = 0;
  logic [10:0] ext_wa;
  logic [15:0] ext_wd;

  always #2.5 clk_i = ~clk_i;

  assign ctl_rdata_i = {5'b0, ctl_addr_o} ^ 16'h5a00;

  always @(posedge clk_i) if (ctl_we_o) begin
    ext_wr <= ext_wr + 1;
    ext_wa <= ctl_addr_o;
    ext_wd <= ctl_wdata_o;
  end

  fbus_responder i_fbus_responder (.*);

  // {func, sub, data, ack length, expected rdata}
  localparam int NV = 23;
  localparam logic [48:0] VEC [NV] = '{
    {4'hA, 11'd3,    16'h1234, 2'd3, 16'h0000},  // R8
    {4'hC, 11'd3,    16'h5678, 2'd3, 16'h0000},
    {4'hD, 11'd15,   16'h9abc, 2'd3, 16'h0000},
    {4'hB, 11'd3,    16'hdead, 2'd3, 16'h0000},
    {4'h2, 11'd3,    16'h0000, 2'd3, 16'h1234},
    {4'h4, 11'd3,    16'h0000, 2'd3, 16'h5678},
    {4'h5, 11'd15,   16'h0000, 2'd3, 16'h9abc},
    {4'h5, 11'd31,   16'h0000, 2'd3, 16'h9abc},  // R8 aliasing
    {4'h8, 11'd0,    16'haaaa, 2'd3, 16'h0000},  // R4
    {4'h8, 11'd0,    16'hbbbb, 2'd3, 16'h0000},
    {4'h1, 11'd0,    16'h0000, 2'd3, 16'h0200},  // R6
    {4'h0, 11'd5,    16'h0000, 2'd1, 16'haaaa},  // R2 R4
    {4'h1, 11'd1,    16'h0000, 2'd3, 16'h0005},  // R7
    {4'h1, 11'd0,    16'h0000, 2'd3, 16'h0201},
    {4'h3, 11'd3,    16'h0000, 2'd0, 16'h0201},  // R1
    {4'h7, 11'd9,    16'h0000, 2'd0, 16'h0201},
    {4'h9, 11'd9,    16'h0000, 2'd0, 16'h0201},
    {4'h1, 11'd1,    16'h0000, 2'd3, 16'h1000},  // R1 R7
    {4'h0, 11'd0,    16'h0000, 2'd1, 16'hbbbb},
    {4'h0, 11'd0,    16'h0000, 2'd1, 16'h0000},  // R5 empty
    {4'h1, 11'd0,    16'h0000, 2'd3, 16'h0202},
    {4'h6, 11'h7ff,  16'h0000, 2'd3, 16'h5dff},  // R9
    {4'hF, 11'd2,    16'h0000, 2'd3, 16'h0000}   // R3
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] f, input logic [10:0] sa, input logic [15:0] d,
                     output int len, output logic [15:0] rd);
    @(negedge clk_i);
    strobe_i = 1'b1; func_i = f; sub_i = sa; wdata_i = d;
    @(negedge clk_i);
    strobe_i = 1'b0;
    rd  = rdata_o;
    len = 0;
    while (!resp_no && len < 8) begin
      len++;
      @(negedge clk_i);
    end
  endtask

  task automatic expect_cmd(input logic [3:0] f, input logic [10:0] sa, input logic [15:0] d,
                            input int elen, input logic [15:0] edat, input string req);
    int len;
    logic [15:0] rd;
    cmd(f, sa, d, len, rd);
    chk(len == elen, {req, " ack"}, len, elen);
    chk(rd == edat, {req, " data"}, rd, edat);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(resp_no == 1'b1, "R12 reset resp", resp_no, 1);
    chk(rdata_o == 16'h0, "R12 reset data", rdata_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      expect_cmd(VEC[i][48:45], VEC[i][44:34], VEC[i][33:18],
                 int'(VEC[i][17:16]), VEC[i][15:0], $sformatf("R1-vec%0d", i));
    end

    // R9 external write
    expect_cmd(4'hE, 11'h012, 16'h4321, 3, 16'h0, "R9 cwr");
    chk(ext_wr == 1, "R9 wr count", ext_wr, 1);
    chk(ext_wa == 11'h012 && ext_wd == 16'h4321, "R9 wr fields", {ext_wa, ext_wd}, {11'h012, 16'h4321});

    // R11 strobe while busy
    @(negedge clk_i);
    strobe_i = 1'b1; func_i = 4'hA; sub_i = 11'd1; wdata_i = 16'h0001;
    @(negedge clk_i);
    func_i = 4'h8; sub_i = 11'd7; wdata_i = 16'h7777;
    @(negedge clk_i);
    strobe_i = 1'b0;
    repeat (4) @(negedge clk_i);
    expect_cmd(4'h1, 11'd1, 16'h0, 3, 16'hA001, "R11 last");
    expect_cmd(4'h1, 11'd0, 16'h0, 3, 16'h0202, "R11 ptr");

    // R10 soft clear
    expect_cmd(4'h8, 11'd0, 16'h1111, 3, 16'h0, "R10 pre push");
    expect_cmd(4'hE, 11'd0, 16'h0080, 3, 16'h0, "R10 clear");
    chk(ext_wr == 2, "R10 forwarded", ext_wr, 2);
    expect_cmd(4'h1, 11'd1, 16'h0, 3, 16'h0000, "R10 last");
    expect_cmd(4'h2, 11'd3, 16'h0, 3, 16'h0000, "R10 bank");
    expect_cmd(4'h1, 11'd0, 16'h0, 3, 16'h0000, "R10 ptr");
    expect_cmd(4'h0, 11'd0, 16'h0, 1, 16'h0000, "R10 empty");

    // R4 R5 R6 full FIFO
    for (int i = 0; i < 1023; i++) begin
      int len;
      logic [15:0] rd;
      cmd(4'h8, 11'd0, 16'(i), len, rd);
    end
    expect_cmd(4'h8, 11'd0, 16'hffff, 3, 16'h0, "R5 full push");
    expect_cmd(4'h1, 11'd0, 16'h0, 3, 16'h0000, "R6 wrap");
    expect_cmd(4'h0, 11'd0, 16'h0, 1, 16'h0000, "R4 first");
    expect_cmd(4'h0, 11'd0, 16'h0, 1, 16'h0001, "R4 second");
    expect_cmd(4'h1, 11'd0, 16'h0, 3, 16'h0002, "R6 after pops");
    begin
      int len;
      logic [15:0] rd;
      logic [15:0] last = '0;
      for (int i = 2; i < 1023; i++) begin
        cmd(4'h0, 11'd0, 16'h0, len, rd);
        last = rd;
      end
      chk(last == 16'd1022, "R5 last kept", last, 1022);
    end
    expect_cmd(4'h0, 11'd0, 16'h0, 1, 16'h0000, "R5 drained");

    // R12 hard reset mid-run
    expect_cmd(4'hA, 11'd2, 16'h00ff, 3, 16'h0, "R12 pre");
    @(negedge clk_i);
    strobe_i = 1'b1; func_i = 4'h2; sub_i = 11'd2;
    @(negedge clk_i);
    rst_ni = 1'b0; strobe_i = 1'b0;
    @(negedge clk_i);
    chk(resp_no == 1'b1, "R12 rst resp", resp_no, 1);
    chk(rdata_o == 16'h0, "R12 rst data", rdata_o, 0);
    rst_ni = 1'b1;
    expect_cmd(4'h2, 11'd2, 16'h0, 3, 16'h0000, "R12 bank");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule